// File: doc/BRIEF.md
# Fully-Associative Line Directory with Tree Pseudo-LRU Placement

This block is the tag side of a 16 KB fully-associative cache with 32-byte lines. It holds 512 entries in one set and keeps only tags and valid bits; data storage and write handling are out of scope. Each request carries a 32-bit byte address. The upper 27 bits form the tag, which is compared against every entry at once. One cycle later the block reports hit or miss and the index of the entry involved. On a miss the line is installed in an entry chosen by the replacement policy.

The default policy is a binary tree of 511 hot/cold bits, all cleared at reset. A cleared bit marks its left child hot and its right child cold. The victim is found by walking from the root and always taking the cold child. Every access, whether a hit or a fill, sets each node on the path so that the touched entry's side becomes hot. The tree alone picks the entry for every fill, including fills into an empty cache. A parameter swaps the tree for exact least-recently-used ordering over the same 512 entries, so the two can be compared.

Top module: `fa_tag_dir`

## Requirements
- R1: After reset every entry is invalid and `resp_valid_o`, `resp_hit_o` and `resp_idx_o` are 0. The first access to any address misses.
- R2: `resp_valid_o` is high in exactly the cycles that follow a cycle with `req_valid_i` high.
- R3: A request hits when its tag `req_addr_i[31:5]` is held by a valid entry. The offset bits `req_addr_i[4:0]` have no effect.
- R4: In tree mode (`POLICY = POL_TREE`) a miss fills the entry reached from the root by taking, at each node, the right child when the node bit is 0 and the left child when it is 1. From reset, the first three distinct misses fill entries 511, 255 and 383.
- R5: In tree mode every access, hit or fill, sets each node on the path to the touched entry to 1 if the path goes right there and to 0 if it goes left. After fills to 511, 255 and 383, a hit on entry 255 makes the next miss fill entry 447.
- R6: The policy chooses every fill even when invalid entries remain. 512 misses to distinct tags from reset fill 512 distinct entries, after which all 512 tags hit. Two back-to-back misses never report the same entry.
- R7: `resp_idx_o` gives the entry holding the tag on a hit, and the entry just filled on a miss.
- R8: In LRU mode (`POLICY = POL_LRU`) a miss fills the least recently used entry. Before any access, the order from least to most recently used is entry 0 up to 511, so the first misses fill 0, 1, 2. Each hit or fill makes the touched entry the most recent.
- R9: A request sees the state left by the request in the cycle directly before it. A fill followed at once by the same tag reports a hit on the same entry.
- R10: A cycle without a request changes no tag, valid bit or policy state, and `resp_hit_o` and `resp_idx_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Lookup request strobe |
| req_addr_i | input | 32 | Byte address of the request |
| resp_valid_o | output | 1 | Response strobe, one cycle after the request |
| resp_hit_o | output | 1 | 1 on a hit, 0 on a miss and fill |
| resp_idx_o | output | 9 | Entry index that was hit or filled |

## Verification
A flipped or stale tree bit sends the next miss to the wrong leaf. That shows up as a wrong `resp_idx_o` on the very next fill, and later as a hit turned into a miss when a line that should have survived was evicted. A wrong valid bit or tag shows on the first request to that line as a wrong hit flag. A bad age update in LRU mode shows as a wrong fill index within a few misses. Because the bench predicts the index and hit flag of every response, each of these faults is seen within the cycle of the first access it affects.

// File: rtl/fa_dir_pkg.sv
package fa_dir_pkg;
  typedef enum logic {
    POL_LRU  = 1'b0,
    POL_TREE = 1'b1
  } repl_pol_e;

  localparam int unsigned DEF_ADDR_W      = 32;
  localparam int unsigned DEF_LINE_BYTES  = 32;
  localparam int unsigned DEF_CACHE_BYTES = 16384;
endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
  parameter int unsigned ENTRIES = 512,
  parameter int unsigned TAG_W   = 27,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [TAG_W-1:0]   tag_i,
  input  logic [TAG_W-1:0]   tags_i [ENTRIES],
  input  logic [ENTRIES-1:0] valid_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (tags_i[g] == tag_i);
  end

  // at most one entry matches, so an OR encoder is exact
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/fa_plru_tree.sv
module fa_plru_tree #(
  parameter int unsigned ENTRIES = 512,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] victim_o
);
  // heap order: node n at bit n-1, children 2n and 2n+1
  logic [ENTRIES-2:0] hot_q;

  always_comb begin
    logic [IDX_W:0] node;
    node = (IDX_W+1)'(1);
    for (int l = 0; l < IDX_W; l++) begin
      node = {node[IDX_W-1:0], ~hot_q[IDX_W'(node - 1'b1)]};
    end
    victim_o = node[IDX_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hot_q <= '0;
    end else if (touch_i) begin
      for (int l = 0; l < IDX_W; l++) begin
        hot_q[IDX_W'(({1'b1, touch_idx_i} >> (IDX_W - l)) - 1'b1)] <= touch_idx_i[IDX_W-1-l];
      end
    end
  end
endmodule

// File: rtl/fa_true_lru.sv
module fa_true_lru #(
  parameter int unsigned ENTRIES = 512,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] victim_o
);
  // ages form a permutation of 0..ENTRIES-1; the oldest is the victim
  logic [IDX_W-1:0] age_q [ENTRIES];
  logic [IDX_W-1:0] touched_age;

  assign touched_age = age_q[touch_idx_i];

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (age_q[i] == IDX_W'(ENTRIES - 1)) victim_o = IDX_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(ENTRIES - 1 - i);
    end else if (touch_i) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx_i)    age_q[i] <= '0;
        else if (age_q[i] < touched_age) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fa_tag_dir.sv
module fa_tag_dir
  import fa_dir_pkg::*;
#(
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned LINE_BYTES  = DEF_LINE_BYTES,
  parameter int unsigned CACHE_BYTES = DEF_CACHE_BYTES,
  parameter repl_pol_e   POLICY      = POL_TREE,
  localparam int unsigned OFF_W      = $clog2(LINE_BYTES),
  localparam int unsigned ENTRIES    = CACHE_BYTES / LINE_BYTES,
  localparam int unsigned IDX_W      = $clog2(ENTRIES),
  localparam int unsigned TAG_W      = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [IDX_W-1:0]  resp_idx_o
);
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   req_tag;
  logic [OFF_W-1:0]   unused_off;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   victim_idx;
  logic [IDX_W-1:0]   touch_idx;

  assign req_tag    = req_addr_i[ADDR_W-1:OFF_W];
  assign unused_off = req_addr_i[OFF_W-1:0];

  fa_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) i_match (
    .tag_i   (req_tag),
    .tags_i  (tag_q),
    .valid_i (valid_q),
    .hit_o   (hit),
    .idx_o   (hit_idx)
  );

  assign touch_idx = hit ? hit_idx : victim_idx;

  if (POLICY == POL_TREE) begin : g_tree
    fa_plru_tree #(.ENTRIES(ENTRIES)) i_repl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .touch_i     (req_valid_i),
      .touch_idx_i (touch_idx),
      .victim_o    (victim_idx)
    );
  end else begin : g_lru
    fa_true_lru #(.ENTRIES(ENTRIES)) i_repl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .touch_i     (req_valid_i),
      .touch_idx_i (touch_idx),
      .victim_o    (victim_idx)
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (req_valid_i && !hit) begin
      valid_q[victim_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (req_valid_i && !hit) tag_q[victim_idx] <= req_tag;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      resp_idx_o   <= '0;
    end else begin
      resp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        resp_hit_o <= hit;
        resp_idx_o <= touch_idx;
      end
    end
  end
endmodule

// File: rtl/fa_tag_dir_chk.sv
module fa_tag_dir_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 5,
  parameter int unsigned IDX_W  = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              resp_valid_o,
  input logic              resp_hit_o,
  input logic [IDX_W-1:0]  resp_idx_o
);
  // R2
  resp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);

  // R2
  no_spurious_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !resp_valid_o);

  // R9
  repeat_tag_hits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && $past(req_valid_i)
     && req_addr_i[ADDR_W-1:OFF_W] == $past(req_addr_i[ADDR_W-1:OFF_W]))
    |=> (resp_hit_o && resp_idx_o == $past(resp_idx_o)));

  // R10
  idle_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(resp_hit_o) && $stable(resp_idx_o)));

  // R6
  distinct_fills_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_hit_o && $past(resp_valid_o) && !$past(resp_hit_o))
    |-> (resp_idx_o != $past(resp_idx_o)));
endmodule

bind fa_tag_dir fa_tag_dir_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_addr_i   (req_addr_i),
  .resp_valid_o (resp_valid_o),
  .resp_hit_o   (resp_hit_o),
  .resp_idx_o   (resp_idx_o)
);

// File: tb/test_fa_tag_dir.sv
module test_fa_tag_dir;
  import fa_dir_pkg::*;

  localparam int N  = 512;
  localparam int IW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_v = 1'b0;
  logic [31:0] req_a = '0;
  logic t_v, t_h, l_v, l_h;
  logic [IW-1:0] t_i, l_i;

  always #4 clk = ~clk;

  fa_tag_dir #(.POLICY(POL_TREE)) i_fa_tag_dir (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_v), .req_addr_i(req_a),
    .resp_valid_o(t_v), .resp_hit_o(t_h), .resp_idx_o(t_i));

  fa_tag_dir #(.POLICY(POL_LRU)) i_fa_tag_dir_lru (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_v), .req_addr_i(req_a),
    .resp_valid_o(l_v), .resp_hit_o(l_h), .resp_idx_o(l_i));

  int checks = 0;
  int errors = 0;

  // reference state
  bit [26:0] mt_tag [N];
  bit        mt_val [N];
  bit        tb_bit [N];
  bit [26:0] ml_tag [N];
  bit        ml_val [N];
  int        lq [$];
  bit        e_v, et_h, el_h;
  int        et_i, el_i;
  int        got_t [$];
  int        got_th [$];
  int        got_l [$];

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", r, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    lq.delete();
    for (int i = 0; i < N; i++) begin
      mt_val[i] = 0; ml_val[i] = 0; tb_bit[i] = 0;
      mt_tag[i] = '0; ml_tag[i] = '0;
      lq.push_back(i);
    end
    e_v = 0; et_h = 0; el_h = 0; et_i = 0; el_i = 0;
  endfunction

  function automatic int tree_victim();
    int n = 1;
    for (int l = 0; l < IW; l++) n = 2 * n + (tb_bit[n] ? 0 : 1);
    return n - N;
  endfunction

  function automatic void tree_touch(int w);
    for (int l = 0; l < IW; l++) begin
      int n = (w + N) >> (IW - l);
      tb_bit[n] = ((w + N) >> (IW - 1 - l)) & 1;
    end
  endfunction

  function automatic void model_access(bit [31:0] a);
    bit [26:0] tg = a[31:5];
    int w;
    et_h = 0;
    for (int i = 0; i < N; i++) if (mt_val[i] && mt_tag[i] == tg) begin et_h = 1; et_i = i; end
    if (!et_h) begin
      et_i = tree_victim(); mt_val[et_i] = 1; mt_tag[et_i] = tg;
    end
    tree_touch(et_i);
    el_h = 0;
    for (int i = 0; i < N; i++) if (ml_val[i] && ml_tag[i] == tg) begin el_h = 1; el_i = i; end
    if (!el_h) begin
      el_i = lq[0]; ml_val[el_i] = 1; ml_tag[el_i] = tg;
    end
    for (int k = 0; k < lq.size(); k++) if (lq[k] == el_i) begin w = k; end
    lq.delete(w);
    lq.push_back(el_i);
  endfunction

  task automatic step(bit v, bit [31:0] a);
    @(negedge clk);
    chk("R2", int'(t_v), int'(e_v));
    chk("R2", int'(l_v), int'(e_v));
    chk(e_v ? "R3" : "R10", int'(t_h), int'(et_h));
    chk(e_v ? "R3" : "R10", int'(l_h), int'(el_h));
    chk(e_v ? (et_h ? "R7" : "R4") : "R10", int'(t_i), et_i);
    chk(e_v ? "R8" : "R10", int'(l_i), el_i);
    if (e_v) begin
      got_t.push_back(int'(t_i)); got_th.push_back(int'(t_h)); got_l.push_back(int'(l_i));
    end
    req_v = v;
    req_a = a;
    e_v = v;
    if (v) model_access(a);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_v = 1'b0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic bit [31:0] mk(int tag, int off);
    return {27'(tag), 5'(off)};
  endfunction

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hits;
    bit seen [N];
    model_reset();
    do_reset();
    // R1
    chk("R1", int'(t_v), 0); chk("R1", int'(t_h), 0); chk("R1", int'(t_i), 0);
    for (int k = 0; k < 3; k++) step(0, '0);

    // R4 R5 R8 R3
    got_t.delete(); got_th.delete(); got_l.delete();
    step(1, mk(100, 0));
    step(1, mk(101, 3));
    step(1, mk(102, 7));
    step(1, mk(101, 31));
    step(1, mk(103, 0));
    step(0, '0);
    chk("R1", got_th[0], 0);
    chk("R4", got_t[0], 511); chk("R4", got_t[1], 255); chk("R4", got_t[2], 383);
    chk("R3", got_th[3], 1);  chk("R7", got_t[3], 255);
    chk("R5", got_t[4], 447);
    chk("R8", got_l[0], 0); chk("R8", got_l[1], 1); chk("R8", got_l[2], 2);
    chk("R8", got_l[3], 1); chk("R8", got_l[4], 3);

    // R9
    got_t.delete(); got_th.delete(); got_l.delete();
    step(1, mk(104, 2));
    step(1, mk(104, 9));
    step(0, '0);
    chk("R9", got_th[1], 1);
    chk("R9", got_t[1], got_t[0]);

    // R6: fill every entry from empty, then replay
    do_reset();
    got_t.delete(); got_th.delete(); got_l.delete();
    for (int k = 0; k < N; k++) step(1, mk(1000 + k, k));
    for (int k = 0; k < N; k++) step(1, mk(1000 + k, 0));
    step(0, '0);
    for (int i = 0; i < N; i++) seen[i] = 0;
    hits = 0;
    for (int k = 0; k < N; k++) seen[got_t[k]] = 1;
    for (int k = N; k < 2 * N; k++) hits += got_th[k];
    for (int i = 0; i < N; i++) chk("R6", int'(seen[i]), 1);
    chk("R6", hits, N);

    // R5 R7 R10: mixed traffic with reuse, evictions and idle gaps
    for (int k = 0; k < 4000; k++) begin
      int tg;
      if ($urandom_range(0, 1) == 0) tg = $urandom_range(0, 15);
      else tg = 2000 + $urandom_range(0, 699);
      step($urandom_range(0, 4) != 0, mk(tg, $urandom_range(0, 31)));
    end
    step(0, '0);
    step(0, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule